// File: doc/BRIEF.md
# Dual-phase frame serial transmitter

This block turns parallel words into a bit stream on one data line. It runs on the transmit bit clock. A frame begins when a frame-sync pulse is sampled. After a programmable delay of zero to two bit times, the block sends a run of words back to back. A frame has one phase or two, and each phase has its own word length and its own word count. The host writes words into a single holding buffer. At the first bit of each word, the buffer contents move into the shift register, and the block raises a ready flag to ask for the next word.

A frame sync that arrives while a frame is still in progress is either ignored or treated as an error, as set by a policy input. When it is treated as an error, the block drops the word it is shifting, sets a sticky error flag and restarts the frame at once, using the usual data delay. Bit order is selectable. It can be MSB first at any supported length, or a fixed 8-bit word sent LSB first or MSB first.

Top module: `tx_dualphase_ser`

## Requirements
- R1: After reset, `ser_out` is 0, `buf_ready` is 1 and `sync_err` is 0.
- R2: In bit-order mode 0, the length code gives the word length: 0=8, 1=12, 2=16, 3=20, 4=24 and 5=32 bits. Codes 6 and 7 give 32 bits. A word of length L is sent as bits L-1 down to 0 of the written word.
- R3: A count value n means n+1 words. A single-phase frame sends `cnt_a`+1 words at length A. A dual-phase frame sends those words and then, with no gap bit, `cnt_b`+1 words at length B.
- R4: Bit-order code 1 sends 8-bit words, bit 0 first. Codes 2 and 3 send 8-bit words, bit 7 first. In these modes the length codes have no effect.
- R5: Let t be the edge that samples `fsync`. With delay code d (0, 1 or 2), bit k of the frame is on `ser_out` after edge t+d+k. Code 3 behaves as 2. The line is 0 during the delay.
- R6: `ser_out` is 0 whenever no frame is in progress, including after the last bit of a frame.
- R7: A write clears `buf_ready` at the next edge. Each word start copies the buffer into the shifter and sets `buf_ready`.
- R8: If the buffer is empty at a word start, the previous word is sent again.
- R9: With `sync_ignore`=0, a frame sync during a frame sets `sync_err` at the same edge and restarts the frame with the data delay. The restarted word is the buffer contents if the buffer was written after the last copy. Otherwise it is the same word as before.
- R10: With `sync_ignore`=1, a frame sync during a frame changes neither the bit stream nor `sync_err`.
- R11: `sync_err` stays set until `err_clr` is sampled high. If a new error and a clear arrive at the same edge, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsync | input | 1 | Frame-sync pulse, sampled on the rising edge |
| wr_en | input | 1 | Host write strobe for the holding buffer |
| wr_data | input | DATA_W | Word to transmit |
| dual_phase | input | 1 | 1 selects a two-phase frame |
| len_a | input | 3 | Word-length code for phase A |
| len_b | input | 3 | Word-length code for phase B |
| cnt_a | input | log2(MAX_WORDS) | Phase A word count minus one |
| cnt_b | input | log2(MAX_WORDS) | Phase B word count minus one |
| bit_order | input | 2 | Bit-order mode |
| sync_ignore | input | 1 | 1 ignores frame syncs that arrive mid-frame |
| delay_code | input | 2 | Data delay after frame sync |
| err_clr | input | 1 | Clears the sticky sync error |
| ser_out | output | 1 | Serial data line |
| buf_ready | output | 1 | Holding buffer can take a word |
| sync_err | output | 1 | Sticky unexpected-sync flag |

## Verification
Let t be the edge that samples `fsync`. Frame bit k is due after edge t+d+k. The bench computes the whole expected bit list for each frame, then compares one bit per cycle at the falling edge that follows each rising edge. It therefore sees the value each edge produced, with no ambiguity about process order. `buf_ready` is checked one edge after each write. `sync_err` is checked at the falling edge after the edge that sampled the mid-frame sync. A restarted frame is expected to show d zero bits, then the restarted word.

// File: rtl/tx_dp_pkg.sv
package tx_dp_pkg;
   localparam int WLEN_W = 6;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DELAY = 2'd1,
      ST_SHIFT = 2'd2
   } tx_state_e;

   typedef struct packed {
      logic [WLEN_W-1:0] len;
      logic              lsb_first;
   } word_fmt_t;

   function automatic logic [WLEN_W-1:0] code_to_len(input logic [2:0] code);
      logic [WLEN_W-1:0] l;
      case (code)
         3'd0:    l = WLEN_W'(8);
         3'd1:    l = WLEN_W'(12);
         3'd2:    l = WLEN_W'(16);
         3'd3:    l = WLEN_W'(20);
         3'd4:    l = WLEN_W'(24);
         default: l = WLEN_W'(32);
      endcase
      return l;
   endfunction
endpackage

// File: rtl/tx_fmt_decode.sv
module tx_fmt_decode
   import tx_dp_pkg::*;
#(
   parameter bit LSB_FIRST_EN = 1'b1
) (
   input  logic [1:0]      bit_order,
   input  logic [2:0]      len_a,
   input  logic [2:0]      len_b,
   input  logic [1:0]      delay_code,
   output word_fmt_t [1:0] fmt,
   output logic [1:0]      delay_sel
);
   logic [1:0][2:0] codes;
   assign codes = {len_b, len_a};

   for (genvar gi = 0; gi < 2; gi++) begin : g_phase
      always_comb begin
         if (bit_order == 2'd0) begin
            fmt[gi].len = code_to_len(codes[gi]);
         end else begin
            fmt[gi].len = WLEN_W'(8);
         end
      end
      if (LSB_FIRST_EN) begin : g_lsb
         assign fmt[gi].lsb_first = (bit_order == 2'd1);
      end else begin : g_msb_only
         assign fmt[gi].lsb_first = 1'b0;
      end
   end

   // reserved delay code saturates at the longest delay
   assign delay_sel = (delay_code == 2'd3) ? 2'd2 : delay_code;
endmodule

// File: rtl/tx_hold_buf.sv
module tx_hold_buf #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   output logic [DATA_W-1:0] word_out,
   output logic              ready
);
   logic [DATA_W-1:0] hold_q;
   logic [DATA_W-1:0] prev_q;
   logic              full_q;

   // an empty buffer hands out the previously sent word again
   assign word_out = full_q ? hold_q : prev_q;
   assign ready    = ~full_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         prev_q <= '0;
         full_q <= 1'b0;
      end else begin
         if (take) begin
            prev_q <= word_out;
         end
         if (wr_en) begin
            hold_q <= wr_data;
            full_q <= 1'b1;
         end else if (take) begin
            full_q <= 1'b0;
         end
      end
   end

   // R7
   write_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !ready);
   // R7
   take_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !wr_en) |=> ready);
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
   import tx_dp_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter bit LSB_FIRST_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              shift,
   input  logic [DATA_W-1:0] word,
   input  word_fmt_t         fmt,
   output logic              bit_out
);
   logic [DATA_W-1:0] sreg_q;
   logic [DATA_W-1:0] aligned;

   // MSB-first words are moved up so that their top bit sits at the register top
   assign aligned = word << (DATA_W - int'(fmt.len));

   if (LSB_FIRST_EN) begin : g_both
      logic dir_lsb_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sreg_q    <= '0;
            dir_lsb_q <= 1'b0;
         end else if (load) begin
            dir_lsb_q <= fmt.lsb_first;
            sreg_q    <= fmt.lsb_first ? word : aligned;
         end else if (shift) begin
            sreg_q <= dir_lsb_q ? {1'b0, sreg_q[DATA_W-1:1]}
                                : {sreg_q[DATA_W-2:0], 1'b0};
         end
      end
      assign bit_out = dir_lsb_q ? sreg_q[0] : sreg_q[DATA_W-1];
   end else begin : g_left
      logic unused_dir;
      assign unused_dir = fmt.lsb_first;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sreg_q <= '0;
         end else if (load) begin
            sreg_q <= aligned;
         end else if (shift) begin
            sreg_q <= {sreg_q[DATA_W-2:0], 1'b0};
         end
      end
      assign bit_out = sreg_q[DATA_W-1];
   end
endmodule

// File: rtl/tx_frame_seq.sv
module tx_frame_seq
   import tx_dp_pkg::*;
#(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fsync,
   input  logic             dual_phase,
   input  logic [CNT_W-1:0] cnt_a,
   input  logic [CNT_W-1:0] cnt_b,
   input  logic             sync_ignore,
   input  logic [1:0]       delay_sel,
   input  word_fmt_t [1:0]  fmt,
   input  logic             err_clr,
   output logic             take,
   output word_fmt_t        start_fmt,
   output logic             shifting,
   output logic             sync_err
);
   tx_state_e         state_q, state_d;
   logic              phase_q, phase_d;
   logic [CNT_W-1:0]  wcnt_q, wcnt_d;
   logic [WLEN_W-1:0] bidx_q, bidx_d;
   logic [1:0]        dly_q, dly_d;
   word_fmt_t         cur_q, cur_d;
   logic              err_q;

   logic busy, last_bit, last_word, frame_end;
   logic sync_ok, sync_bad, restart;

   assign busy      = (state_q != ST_IDLE);
   assign shifting  = (state_q == ST_SHIFT);
   assign last_bit  = shifting && (bidx_q == cur_q.len - WLEN_W'(1));
   assign last_word = (wcnt_q == (phase_q ? cnt_b : cnt_a));
   assign frame_end = last_bit && last_word && (phase_q || !dual_phase);
   // a sync on the edge that finishes the last bit opens the next frame cleanly
   assign sync_ok   = fsync && (!busy || frame_end);
   assign sync_bad  = fsync && busy && !frame_end;
   assign restart   = sync_ok || (sync_bad && !sync_ignore);
   assign sync_err  = err_q;

   always_comb begin
      state_d   = state_q;
      phase_d   = phase_q;
      wcnt_d    = wcnt_q;
      bidx_d    = bidx_q;
      dly_d     = dly_q;
      cur_d     = cur_q;
      take      = 1'b0;
      start_fmt = fmt[0];
      if (restart) begin
         phase_d = 1'b0;
         wcnt_d  = '0;
         if (delay_sel == 2'd0) begin
            take = 1'b1;
         end else begin
            state_d = ST_DELAY;
            dly_d   = delay_sel - 2'd1;
         end
      end else begin
         case (state_q)
            ST_DELAY: begin
               if (dly_q == 2'd0) begin
                  take = 1'b1;
               end else begin
                  dly_d = dly_q - 2'd1;
               end
            end
            ST_SHIFT: begin
               if (!last_bit) begin
                  bidx_d = bidx_q + WLEN_W'(1);
               end else if (frame_end) begin
                  state_d = ST_IDLE;
               end else if (last_word) begin
                  phase_d   = 1'b1;
                  wcnt_d    = '0;
                  take      = 1'b1;
                  start_fmt = fmt[1];
               end else begin
                  wcnt_d    = wcnt_q + CNT_W'(1);
                  take      = 1'b1;
                  start_fmt = phase_q ? fmt[1] : fmt[0];
               end
            end
            default: ;
         endcase
      end
      if (take) begin
         state_d = ST_SHIFT;
         bidx_d  = '0;
         cur_d   = start_fmt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         phase_q <= 1'b0;
         wcnt_q  <= '0;
         bidx_q  <= '0;
         dly_q   <= '0;
         cur_q   <= '0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         phase_q <= phase_d;
         wcnt_q  <= wcnt_d;
         bidx_q  <= bidx_d;
         dly_q   <= dly_d;
         cur_q   <= cur_d;
         if (sync_bad && !sync_ignore) begin
            err_q <= 1'b1;
         end else if (err_clr) begin
            err_q <= 1'b0;
         end
      end
   end

   // R11
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_err && !err_clr) |=> sync_err);
   // R10
   ignore_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_ignore && !sync_err) |=> !sync_err);
   // R9
   abort_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && fsync && !frame_end && !sync_ignore) |=> sync_err);
   // R5
   zero_delay_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && fsync && delay_sel == 2'd0) |=> (shifting && bidx_q == '0));
   // R5
   delay_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && fsync && delay_sel != 2'd0) |=> (state_q == ST_DELAY));
endmodule

// File: rtl/tx_dualphase_ser.sv
module tx_dualphase_ser
   import tx_dp_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int MAX_WORDS    = 128,
   parameter bit LSB_FIRST_EN = 1'b1,
   localparam int CNT_W       = $clog2(MAX_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fsync,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              dual_phase,
   input  logic [2:0]        len_a,
   input  logic [2:0]        len_b,
   input  logic [CNT_W-1:0]  cnt_a,
   input  logic [CNT_W-1:0]  cnt_b,
   input  logic [1:0]        bit_order,
   input  logic              sync_ignore,
   input  logic [1:0]        delay_code,
   input  logic              err_clr,
   output logic              ser_out,
   output logic              buf_ready,
   output logic              sync_err
);
   if (DATA_W != 32) begin : g_bad_width
      $error("DATA_W must be 32 to hold the longest word length");
   end
   if (MAX_WORDS < 2 || (1 << CNT_W) != MAX_WORDS) begin : g_bad_count
      $error("MAX_WORDS must be a power of two of at least 2");
   end

   word_fmt_t [1:0]   fmt;
   word_fmt_t         start_fmt;
   logic [1:0]        delay_sel;
   logic              take, shifting, shift_bit;
   logic [DATA_W-1:0] next_word;

   tx_fmt_decode #(.LSB_FIRST_EN(LSB_FIRST_EN)) u_dec (
      .bit_order (bit_order),
      .len_a     (len_a),
      .len_b     (len_b),
      .delay_code(delay_code),
      .fmt       (fmt),
      .delay_sel (delay_sel)
   );

   tx_frame_seq #(.CNT_W(CNT_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .fsync      (fsync),
      .dual_phase (dual_phase),
      .cnt_a      (cnt_a),
      .cnt_b      (cnt_b),
      .sync_ignore(sync_ignore),
      .delay_sel  (delay_sel),
      .fmt        (fmt),
      .err_clr    (err_clr),
      .take       (take),
      .start_fmt  (start_fmt),
      .shifting   (shifting),
      .sync_err   (sync_err)
   );

   tx_hold_buf #(.DATA_W(DATA_W)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .take    (take),
      .word_out(next_word),
      .ready   (buf_ready)
   );

   tx_shifter #(.DATA_W(DATA_W), .LSB_FIRST_EN(LSB_FIRST_EN)) u_shf (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (take),
      .shift  (shifting && !take),
      .word   (next_word),
      .fmt    (start_fmt),
      .bit_out(shift_bit)
   );

   assign ser_out = shifting & shift_bit;

   // R7
   copy_empties_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !wr_en) |=> buf_ready);
endmodule

// File: tb/tx_dualphase_ser_tb.sv
module tx_dualphase_ser_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fsync = 1'b0, wr_en = 1'b0, dual_phase = 1'b0;
   logic [31:0] wr_data = '0;
   logic [2:0]  len_a = '0, len_b = '0;
   logic [6:0]  cnt_a = '0, cnt_b = '0;
   logic [1:0]  bit_order = '0, delay_code = '0;
   logic        sync_ignore = 1'b0, err_clr = 1'b0;
   logic        ser_out, buf_ready, sync_err;
   int          n_vec = 0, n_bad = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   tx_dualphase_ser u_dut (
      .clk(clk), .rst_n(rst_n), .fsync(fsync), .wr_en(wr_en), .wr_data(wr_data),
      .dual_phase(dual_phase), .len_a(len_a), .len_b(len_b), .cnt_a(cnt_a),
      .cnt_b(cnt_b), .bit_order(bit_order), .sync_ignore(sync_ignore),
      .delay_code(delay_code), .err_clr(err_clr), .ser_out(ser_out),
      .buf_ready(buf_ready), .sync_err(sync_err)
   );

   task automatic chk(input logic act, input logic exp, input string what);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b at %0t", what, act, exp, $time);
      end
   endtask

   function automatic int elen(input logic [2:0] c, input logic [1:0] o);
      if (o != 2'd0) return 8;
      if (c < 3'd5) return 8 + 4 * int'(c);
      return 32;
   endfunction

   function automatic logic ebit(input logic [31:0] w, input int l,
                                 input logic [1:0] o, input int i);
      if (o == 2'd1) return w[i];
      return w[l-1-i];
   endfunction

   task automatic run_frame(input bit dp, input logic [2:0] la, input logic [2:0] lb,
                            input logic [6:0] ca, input logic [6:0] cb,
                            input logic [1:0] ord, input logic [1:0] dc,
                            input int nwr_in, input string tag);
      logic [31:0] wl[$];
      bit          q[$];
      int          nw, nwr, d, wi;
      bit          wrote;
      nw  = int'(ca) + 1 + (dp ? int'(cb) + 1 : 0);
      nwr = (nwr_in < 1) ? 1 : ((nwr_in > nw) ? nw : nwr_in);
      d   = (dc == 2'd3) ? 2 : int'(dc);
      for (int k = 0; k < nwr; k++) wl.push_back($urandom);
      for (int k = 0; k < nw; k++) begin
         int l;
         logic [31:0] w;
         l = (k <= int'(ca)) ? elen(la, ord) : elen(lb, ord);
         w = (k < nwr) ? wl[k] : wl[nwr-1];
         for (int i = 0; i < l; i++) q.push_back(ebit(w, l, ord, i));
      end
      @(negedge clk);
      dual_phase = dp; len_a = la; len_b = lb; cnt_a = ca; cnt_b = cb;
      bit_order = ord; delay_code = dc; sync_ignore = 1'b0;
      wr_en = 1'b1; wr_data = wl[0];
      @(negedge clk);
      wr_en = 1'b0; fsync = 1'b1; wi = 1; wrote = 1'b0;
      for (int j = 0; j < d + q.size() + 3; j++) begin
         logic e;
         @(negedge clk);
         fsync = 1'b0; wr_en = 1'b0;
         e = (j < d) ? 1'b0 : ((j - d < q.size()) ? q[j-d] : 1'b0);
         chk(ser_out, e, {tag, " ser_out (R5 R6)"});
         if (wrote) chk(buf_ready, 1'b0, "R7 buf_ready after write");
         wrote = 1'b0;
         if (buf_ready && wi < nwr) begin
            wr_en = 1'b1; wr_data = wl[wi]; wi++; wrote = 1'b1;
         end
      end
      @(negedge clk);
      wr_en = 1'b0;
      chk(sync_err, 1'b0, {tag, " no sync error on clean frame"});
   endtask

   task automatic expect_word8(input logic [31:0] w, input int d, input string tag);
      for (int j = 0; j < d + 9; j++) begin
         @(negedge clk);
         fsync = 1'b0;
         chk(ser_out, (j < d) ? 1'b0 : ((j - d < 8) ? w[7-(j-d)] : 1'b0), tag);
      end
   endtask

   task automatic start_short(input logic [31:0] w, input bit ign);
      @(negedge clk);
      dual_phase = 1'b0; len_a = 3'd0; cnt_a = 7'd0; bit_order = 2'd0;
      delay_code = 2'd1; sync_ignore = ign;
      wr_en = 1'b1; wr_data = w;
      @(negedge clk);
      wr_en = 1'b0; fsync = 1'b1;
      @(negedge clk);
      fsync = 1'b0;
      chk(ser_out, 1'b0, "R5 delay bit");
   endtask

   initial begin
      logic [31:0] wa, wb;
      void'($urandom(32'h1a2b3c4d));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(ser_out, 1'b0, "R1 ser_out");
      chk(buf_ready, 1'b1, "R1 buf_ready");
      chk(sync_err, 1'b0, "R1 sync_err");

      // R2 each length code, incl. reserved 6 and 7
      for (int c = 0; c < 8; c++) run_frame(0, 3'(c), 3'd0, 7'd1, 7'd0, 2'd0, 2'd0, 2, "R2");
      // R3 dual phase with different lengths, and a full 128-word phase
      run_frame(1, 3'd1, 3'd5, 7'd2, 7'd1, 2'd0, 2'd1, 5, "R3");
      run_frame(0, 3'd0, 3'd0, 7'd127, 7'd0, 2'd0, 2'd0, 128, "R3 max count");
      // R4 byte modes ignore the length codes
      run_frame(1, 3'd5, 3'd3, 7'd1, 7'd1, 2'd1, 2'd0, 4, "R4 lsb");
      run_frame(0, 3'd4, 3'd0, 7'd2, 7'd0, 2'd2, 2'd0, 3, "R4 msb8");
      run_frame(0, 3'd2, 3'd0, 7'd1, 7'd0, 2'd3, 2'd2, 2, "R4 msb8 alt");
      // R5 delays incl. reserved code
      run_frame(0, 3'd0, 3'd0, 7'd0, 7'd0, 2'd0, 2'd2, 1, "R5 d2");
      run_frame(0, 3'd0, 3'd0, 7'd0, 7'd0, 2'd0, 2'd3, 1, "R5 d3");
      // R8 underrun repeats the previous word
      run_frame(1, 3'd0, 3'd2, 7'd1, 7'd1, 2'd0, 2'd1, 1, "R8");

      // R9 abort, no new write: same word again
      wa = $urandom;
      start_short(wa, 1'b0);
      @(negedge clk); chk(ser_out, wa[7], "R9 bit7");
      chk(buf_ready, 1'b1, "R7 ready after copy");
      @(negedge clk); chk(ser_out, wa[6], "R9 bit6");
      @(negedge clk); chk(ser_out, wa[5], "R9 bit5");
      fsync = 1'b1;
      @(negedge clk); fsync = 1'b0;
      chk(sync_err, 1'b1, "R9 sync_err set");
      chk(ser_out, 1'b0, "R9 restart delay");
      expect_word8(wa, 0, "R9 resend same word");
      // R11 sticky until cleared
      repeat (3) @(negedge clk);
      chk(sync_err, 1'b1, "R11 still set");
      err_clr = 1'b1;
      @(negedge clk); err_clr = 1'b0;
      chk(sync_err, 1'b0, "R11 cleared");

      // R9 abort after a new write: new word
      wa = $urandom; wb = $urandom;
      start_short(wa, 1'b0);
      @(negedge clk); chk(ser_out, wa[7], "R9 bit7");
      wr_en = 1'b1; wr_data = wb;
      @(negedge clk); wr_en = 1'b0; chk(ser_out, wa[6], "R9 bit6");
      @(negedge clk); chk(ser_out, wa[5], "R9 bit5");
      fsync = 1'b1;
      @(negedge clk); fsync = 1'b0;
      chk(sync_err, 1'b1, "R9 sync_err set");
      chk(ser_out, 1'b0, "R9 restart delay");
      expect_word8(wb, 0, "R9 new word after restart");
      err_clr = 1'b1;
      @(negedge clk); err_clr = 1'b0;

      // R10 ignored mid-frame sync
      wa = $urandom;
      start_short(wa, 1'b1);
      @(negedge clk); chk(ser_out, wa[7], "R10 bit7");
      @(negedge clk); chk(ser_out, wa[6], "R10 bit6");
      @(negedge clk); chk(ser_out, wa[5], "R10 bit5");
      fsync = 1'b1;
      for (int k = 4; k >= -1; k--) begin
         @(negedge clk); fsync = 1'b0;
         chk(ser_out, (k >= 0) ? wa[k] : 1'b0, "R10 stream unchanged");
      end
      chk(sync_err, 1'b0, "R10 no error");
      sync_ignore = 1'b0;

      // random frames
      for (int n = 0; n < 40; n++) begin
         logic [2:0] ra, rb;
         logic [6:0] xa, xb;
         ra = 3'($urandom_range(7)); rb = 3'($urandom_range(7));
         xa = 7'($urandom_range(3)); xb = 7'($urandom_range(3));
         run_frame(1'($urandom_range(1)), ra, rb, xa, xb, 2'($urandom_range(3)),
                   2'($urandom_range(3)), $urandom_range(1, 8), "R2 R3 R4 R8 random");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule